// File: doc/BRIEF.md
# Per-core interrupt CPU interface

This block connects the interrupt distributor to a single processor core. The distributor presents its current best candidate for this core: an ID, an 8-bit priority (numerically lower means more urgent) and a group bit. The block checks that candidate against a software-set priority mask and against the priority of the interrupt the core is already servicing. It then drives one of two request lines into the core, either the normal IRQ line or the fast FIQ line.

Software works through a small register window at byte offsets 0x2000 to 0x2018. Reading the acknowledge register hands the candidate's ID to the core, moves that interrupt from pending to active, and pushes its group priority onto a small stack of active priorities. Writing the same ID to the end-of-interrupt register retires it and restores the previous running priority. Nested handlers can therefore preempt each other, but only when the newcomer's group priority is strictly more urgent. The binary point register decides which priority bits form the group priority. The candidate input is a level with no back-pressure: the block samples it every cycle and never stalls the distributor. Acknowledges and retirements go back to the distributor as one-cycle pulses that carry the ID.

A register access is a one-cycle strobe. It is always accepted, and read data returns one cycle later together with a valid pulse.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset both request lines are low, the control register (0x2000) reads 0, the mask register (0x2004) reads 0, the running-priority register (0x2014) reads 0xFF, and the highest-pending register (0x2018) reads the spurious ID 1023 because a mask of 0 blocks everything.
- R2: A candidate is eligible only when it is valid and its priority is numerically below the mask register value in bits [7:0].
- R3: Control bit 0 is the signalling enable. While it is 0, neither request line is raised, although register reads still report eligibility.
- R4: Control bit 1 routes group-0 candidates (group bit 0) to FIQ. Group-1 candidates, and all candidates while bit 1 is 0, use IRQ. At most one line is high at any time.
- R5: A read of 0x200C while a candidate is eligible returns its ID, makes it active, sets the running priority to its group priority, and pulses the acknowledge output with the ID.
- R6: A read of 0x200C with no eligible candidate returns 1023 and changes no state: no acknowledge pulse and no change to the running priority.
- R7: The binary point register (0x2008, bits [2:0], value b) makes bits [b:0] subpriority. The group priority is the priority with those bits cleared. A candidate is eligible only if its group priority is strictly below the running priority.
- R8: Writing 0x2010 with a value equal to the most recently activated ID pops that entry, restores the previous running priority (0xFF when none is left) and pulses the end-of-interrupt output. Any other value is ignored.
- R9: A read of 0x2018 returns the eligible candidate's ID, or 1023 when there is none, and changes no state.
- R10: While DEPTH interrupts are active, nothing is eligible and an acknowledge read returns 1023.
- R11: Read data and its valid pulse appear on the cycle after the read strobe. Request lines are registered and follow their inputs after one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cand_valid_i | input | 1 | Distributor has a candidate for this core |
| cand_id_i | input | ID_W | Candidate interrupt ID |
| cand_prio_i | input | PRIO_W | Candidate priority, lower is more urgent |
| cand_grp1_i | input | 1 | Candidate group: 0 = group 0, 1 = group 1 |
| reg_sel_i | input | 1 | Register access strobe |
| reg_wr_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 16 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the strobe |
| reg_rvalid_o | output | 1 | Read data valid pulse |
| irq_o | output | 1 | Normal interrupt request to the core |
| fiq_o | output | 1 | Fast interrupt request to the core |
| ack_valid_o | output | 1 | Pulse: an interrupt became active |
| ack_id_o | output | ID_W | ID of the acknowledged interrupt |
| eoi_valid_o | output | 1 | Pulse: an active interrupt retired |
| eoi_id_o | output | ID_W | ID of the retired interrupt |

## Verification
The active-priority stack is the state most likely to go wrong, and the bench observes it only through the running-priority register. A wrong push or pop appears on the very next read of 0x2014. It also changes which candidates the highest-pending read and the request lines accept one cycle later. Sweeps over every binary point setting, across candidates just above and just below the split, show an off-by-one in the group mask as a wrong request level or pending ID. A mismatched or missing retirement leaves the running priority stuck, and a later preemption test then fails.

// File: rtl/cif_pkg.sv
package cif_pkg;
  localparam logic [15:0] OFS_CTRL  = 16'h2000;
  localparam logic [15:0] OFS_MASK  = 16'h2004;
  localparam logic [15:0] OFS_BINPT = 16'h2008;
  localparam logic [15:0] OFS_ACK   = 16'h200C;
  localparam logic [15:0] OFS_DONE  = 16'h2010;
  localparam logic [15:0] OFS_RUN   = 16'h2014;
  localparam logic [15:0] OFS_PEND  = 16'h2018;

  localparam int unsigned SPURIOUS_ID = 1023;

  // control register layout: bit 0 signalling enable, bit 1 fast-line routing
  typedef struct packed {
    logic fiq_route;
    logic sig_en;
  } ctrl_t;
endpackage

// File: rtl/cif_gate.sv
// Decides whether the distributor candidate may be taken by this core now.
module cif_gate #(
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned BP_W   = 3
) (
  input  logic              cand_valid,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic [PRIO_W-1:0] mask,
  input  logic [BP_W-1:0]   bpt,
  input  logic [PRIO_W-1:0] run_prio,
  input  logic              stack_full,
  output logic [PRIO_W-1:0] grp_prio,
  output logic              eligible
);
  logic [PRIO_W-1:0] sub_bits;

  always_comb begin
    for (int i = 0; i < int'(PRIO_W); i++) begin
      sub_bits[i] = (i <= int'(bpt));
    end
  end

  assign grp_prio = cand_prio & ~sub_bits;
  assign eligible = cand_valid && (cand_prio < mask) &&
                    (grp_prio < run_prio) && !stack_full;
endmodule

// File: rtl/cif_active_stack.sv
// Stack of active interrupts: ID and group priority per level.
module cif_active_stack #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ID_W   = 10,
  parameter int unsigned PRIO_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ID_W-1:0]   push_id,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic [ID_W-1:0]   top_id,
  output logic [PRIO_W-1:0] top_prio,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count
);
  logic [ID_W-1:0]   id_q   [DEPTH];
  logic [PRIO_W-1:0] prio_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;

  for (genvar s = 0; s < int'(DEPTH); s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        id_q[s]   <= '0;
        prio_q[s] <= '1;
      end else if (push && cnt_q == CNT_W'(s)) begin
        id_q[s]   <= push_id;
        prio_q[s] <= push_prio;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (push && !full)  cnt_q <= cnt_q + 1'b1;
    else if (pop && !empty)  cnt_q <= cnt_q - 1'b1;
  end

  always_comb begin
    top_id   = '0;
    top_prio = '1;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (cnt_q == CNT_W'(i + 1)) begin
        top_id   = id_q[i];
        top_prio = prio_q[i];
      end
    end
  end

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
  import cif_pkg::*;
#(
  parameter int unsigned ID_W   = 10,
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic              cand_grp1_i,
  input  logic              reg_sel_i,
  input  logic              reg_wr_i,
  input  logic [15:0]       reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              reg_rvalid_o,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              ack_valid_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic              eoi_valid_o,
  output logic [ID_W-1:0]   eoi_id_o
);
  localparam int unsigned BP_W  = 3;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  ctrl_t             ctrl_q;
  logic [PRIO_W-1:0] mask_q;
  logic [BP_W-1:0]   bpt_q;

  logic [PRIO_W-1:0] run_prio;
  logic [PRIO_W-1:0] cand_grp;
  logic [ID_W-1:0]   top_id;
  logic              stk_full, stk_empty, eligible;
  logic [CNT_W-1:0]  act_cnt;

  logic rd_req, wr_req, rd_ack, do_push, do_pop;
  logic [31:0] rd_next;
  logic [31:0] pick_id;

  assign rd_req  = reg_sel_i && !reg_wr_i;
  assign wr_req  = reg_sel_i && reg_wr_i;
  assign rd_ack  = rd_req && (reg_addr_i == OFS_ACK);
  assign do_push = rd_ack && eligible;
  assign do_pop  = wr_req && (reg_addr_i == OFS_DONE) && !stk_empty &&
                   (reg_wdata_i == 32'(top_id));

  cif_gate #(.PRIO_W(PRIO_W), .BP_W(BP_W)) u_gate (
    .cand_valid (cand_valid_i),
    .cand_prio  (cand_prio_i),
    .mask       (mask_q),
    .bpt        (bpt_q),
    .run_prio   (run_prio),
    .stack_full (stk_full),
    .grp_prio   (cand_grp),
    .eligible   (eligible)
  );

  cif_active_stack #(.DEPTH(DEPTH), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (do_push),
    .push_id   (cand_id_i),
    .push_prio (cand_grp),
    .pop       (do_pop),
    .top_id    (top_id),
    .top_prio  (run_prio),
    .full      (stk_full),
    .empty     (stk_empty),
    .count     (act_cnt)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      bpt_q  <= '0;
    end else if (wr_req) begin
      unique case (reg_addr_i)
        OFS_CTRL:  ctrl_q <= ctrl_t'(reg_wdata_i[1:0]);
        OFS_MASK:  mask_q <= reg_wdata_i[PRIO_W-1:0];
        OFS_BINPT: bpt_q  <= reg_wdata_i[BP_W-1:0];
        default: ;
      endcase
    end
  end

  // read path
  assign pick_id = eligible ? 32'(cand_id_i) : 32'(SPURIOUS_ID);

  always_comb begin
    unique case (reg_addr_i)
      OFS_CTRL:  rd_next = 32'(ctrl_q);
      OFS_MASK:  rd_next = 32'(mask_q);
      OFS_BINPT: rd_next = 32'(bpt_q);
      OFS_ACK:   rd_next = pick_id;
      OFS_RUN:   rd_next = 32'(run_prio);
      OFS_PEND:  rd_next = pick_id;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata_o  <= '0;
      reg_rvalid_o <= 1'b0;
    end else begin
      reg_rvalid_o <= rd_req;
      if (rd_req) reg_rdata_o <= rd_next;
    end
  end

  // handshake pulses towards the distributor
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid_o <= 1'b0;
      ack_id_o    <= '0;
      eoi_valid_o <= 1'b0;
      eoi_id_o    <= '0;
    end else begin
      ack_valid_o <= do_push;
      eoi_valid_o <= do_pop;
      if (do_push) ack_id_o <= cand_id_i;
      if (do_pop)  eoi_id_o <= top_id;
    end
  end

  // request lines to the core
  logic want, to_fast;
  assign want    = ctrl_q.sig_en && eligible;
  assign to_fast = ctrl_q.fiq_route && !cand_grp1_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= want && !to_fast;
      fiq_o <= want && to_fast;
    end
  end
endmodule

// File: rtl/cif_checker.sv
module cif_checker
  import cif_pkg::*;
#(
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              fiq,
  input logic              ack_valid,
  input logic              eoi_valid,
  input logic              rvalid,
  input logic              reg_sel,
  input logic              reg_wr,
  input logic [15:0]       reg_addr,
  input logic              cand_valid,
  input logic [PRIO_W-1:0] cand_prio,
  input logic [PRIO_W-1:0] mask,
  input logic              ctrl_en,
  input logic [PRIO_W-1:0] run_prio,
  input logic [CNT_W-1:0]  depth_cnt
);
  a_r4_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq, fiq}));

  a_r3_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || fiq) |-> $past(ctrl_en));

  a_r2_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || fiq) |-> $past(cand_valid && (cand_prio < mask)));

  a_r5_running_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (run_prio < $past(run_prio)));

  a_r6_ack_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(reg_sel && !reg_wr && reg_addr == OFS_ACK));

  a_r8_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> ({1'b0, depth_cnt} + 1'b1) == {1'b0, $past(depth_cnt)});

  a_r10_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    depth_cnt <= CNT_W'(DEPTH));

  a_r11_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(reg_sel && !reg_wr));
endmodule

bind cpu_irq_iface cif_checker #(.PRIO_W(PRIO_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq        (irq_o),
  .fiq        (fiq_o),
  .ack_valid  (ack_valid_o),
  .eoi_valid  (eoi_valid_o),
  .rvalid     (reg_rvalid_o),
  .reg_sel    (reg_sel_i),
  .reg_wr     (reg_wr_i),
  .reg_addr   (reg_addr_i),
  .cand_valid (cand_valid_i),
  .cand_prio  (cand_prio_i),
  .mask       (mask_q),
  .ctrl_en    (ctrl_q.sig_en),
  .run_prio   (run_prio),
  .depth_cnt  (act_cnt)
);

// File: tb/test_cpu_irq_iface.sv
module test_cpu_irq_iface;
  localparam int ID_W = 10;
  localparam int PRIO_W = 8;
  localparam int DEPTH = 4;
  localparam logic [15:0] A_CTRL = 16'h2000, A_MASK = 16'h2004, A_BP = 16'h2008,
                          A_ACK = 16'h200C, A_DONE = 16'h2010, A_RUN = 16'h2014,
                          A_PEND = 16'h2018;
  localparam logic [31:0] SPUR = 32'd1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cand_valid = 1'b0;
  logic [ID_W-1:0] cand_id = '0;
  logic [PRIO_W-1:0] cand_prio = '0;
  logic cand_g1 = 1'b0;
  logic sel = 1'b0, wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid, irq, fiq, ackv, eoiv;
  logic [ID_W-1:0] ack_id, eoi_id;

  int n_cmp = 0;
  int n_bad = 0;
  logic last_ack, last_rv, last_eoi;

  always #4 clk = ~clk;

  cpu_irq_iface #(.ID_W(ID_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH)) i_cpu_irq_iface (
    .clk(clk), .rst_n(rst_n),
    .cand_valid_i(cand_valid), .cand_id_i(cand_id), .cand_prio_i(cand_prio),
    .cand_grp1_i(cand_g1),
    .reg_sel_i(sel), .reg_wr_i(wr_en), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .reg_rvalid_o(rvalid),
    .irq_o(irq), .fiq_o(fiq),
    .ack_valid_o(ackv), .ack_id_o(ack_id),
    .eoi_valid_o(eoiv), .eoi_id_o(eoi_id)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0;
    last_eoi = eoiv;
  endtask

  task automatic reg_rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr_en = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    d = rdata; last_ack = ackv; last_rv = rvalid;
  endtask

  task automatic set_cand(input logic v, input int id, input int prio, input logic g1);
    @(negedge clk);
    cand_valid = v; cand_id = ID_W'(id); cand_prio = PRIO_W'(prio); cand_g1 = g1;
    @(negedge clk);
  endtask

  function automatic logic [7:0] grp(input logic [7:0] p, input int b);
    return p & ~8'((1 << (b + 1)) - 1);
  endfunction

  logic [7:0] pm_list [4] = '{8'h00, 8'h10, 8'h80, 8'hFF};
  logic [7:0] pr_list [7] = '{8'h00, 8'h0F, 8'h10, 8'h11, 8'h7F, 8'h80, 8'hFE};
  logic [7:0] pp_list [7] = '{8'h00, 8'h3F, 8'h40, 8'h7E, 8'h7F, 8'h80, 8'hC0};

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 fiq", 32'(fiq), 0);
    reg_rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    chk("R11 rvalid", 32'(last_rv), 1);
    @(negedge clk); chk("R11 rvalid drops", 32'(rvalid), 0);
    reg_rd(A_MASK, d); chk("R1 mask", d, 0);
    reg_rd(A_RUN, d);  chk("R1 running", d, 32'hFF);
    set_cand(1, 7, 0, 1);
    reg_rd(A_PEND, d); chk("R1 pending", d, SPUR);
    chk("R1 irq with zero mask", 32'(irq), 0);

    // R2 mask sweep
    reg_wr(A_CTRL, 1);
    reg_wr(A_BP, 0);
    foreach (pm_list[i]) begin
      reg_wr(A_MASK, 32'(pm_list[i]));
      foreach (pr_list[j]) begin
        set_cand(1, 20 + j, int'(pr_list[j]), 1);
        exp = pr_list[j] < pm_list[i];
        chk("R2 irq vs mask", 32'(irq), 32'(exp));
        reg_rd(A_PEND, d);
        chk("R2 pending vs mask", d, exp ? 32'(20 + j) : SPUR);
      end
    end

    // R3 enable gating, R9 pending read leaves state alone
    reg_wr(A_MASK, 32'hFF);
    reg_wr(A_CTRL, 0);
    set_cand(1, 33, 8'h10, 0);
    chk("R3 irq off", 32'(irq), 0);
    chk("R3 fiq off", 32'(fiq), 0);
    reg_rd(A_PEND, d); chk("R9 pending id", d, 33);
    chk("R9 no ack pulse", 32'(last_ack), 0);
    reg_rd(A_RUN, d);  chk("R9 running unchanged", d, 32'hFF);

    // R4 routing
    reg_wr(A_CTRL, 3); @(negedge clk);
    chk("R4 group0 fiq", 32'(fiq), 1);
    chk("R4 group0 not irq", 32'(irq), 0);
    set_cand(1, 34, 8'h10, 1);
    chk("R4 group1 irq", 32'(irq), 1);
    chk("R4 group1 not fiq", 32'(fiq), 0);
    reg_wr(A_CTRL, 1); set_cand(1, 35, 8'h10, 0);
    chk("R4 no routing irq", 32'(irq), 1);
    chk("R4 no routing fiq", 32'(fiq), 0);

    // R5 / R7 binary point sweep
    for (int b = 0; b < 8; b++) begin
      reg_wr(A_BP, 32'(b));
      set_cand(1, 100 + b, 8'h80, 1);
      reg_rd(A_ACK, d);
      chk("R5 ack id", d, 32'(100 + b));
      chk("R5 ack pulse", 32'(last_ack), 1);
      chk("R5 ack id out", 32'(ack_id), 32'(100 + b));
      reg_rd(A_RUN, d);
      chk("R5 running group", d, 32'(grp(8'h80, b)));
      foreach (pp_list[k]) begin
        set_cand(1, 200, int'(pp_list[k]), 1);
        exp = grp(pp_list[k], b) < grp(8'h80, b);
        chk("R7 preempt irq", 32'(irq), 32'(exp));
        reg_rd(A_PEND, d);
        chk("R7 preempt pending", d, exp ? 32'd200 : SPUR);
      end
      set_cand(0, 0, 0, 1);
      reg_wr(A_DONE, 32'(100 + b));
      chk("R8 retire pulse", 32'(last_eoi), 1);
      reg_rd(A_RUN, d); chk("R8 running idle", d, 32'hFF);
    end

    // R6 spurious
    reg_wr(A_BP, 0);
    reg_rd(A_ACK, d); chk("R6 no candidate", d, SPUR);
    chk("R6 no pulse", 32'(last_ack), 0);
    reg_wr(A_MASK, 32'h10);
    set_cand(1, 40, 8'h20, 1);
    reg_rd(A_ACK, d); chk("R6 masked", d, SPUR);
    reg_rd(A_RUN, d); chk("R6 running kept", d, 32'hFF);
    reg_wr(A_MASK, 32'hFF);

    // R8 nesting and mismatched retirement
    set_cand(1, 5, 8'h80, 1); reg_rd(A_ACK, d); chk("R8 first ack", d, 5);
    set_cand(1, 6, 8'h40, 1); reg_rd(A_ACK, d); chk("R8 nested ack", d, 6);
    reg_rd(A_RUN, d); chk("R8 nested running", d, 32'h40);
    set_cand(0, 0, 0, 1);
    reg_wr(A_DONE, 5); chk("R8 mismatch no pulse", 32'(last_eoi), 0);
    reg_rd(A_RUN, d);  chk("R8 mismatch ignored", d, 32'h40);
    reg_wr(A_DONE, 6); chk("R8 pulse", 32'(last_eoi), 1);
    chk("R8 retired id", 32'(eoi_id), 6);
    reg_rd(A_RUN, d);  chk("R8 restored", d, 32'h80);
    reg_wr(A_DONE, 6); chk("R8 stale id ignored", 32'(last_eoi), 0);
    reg_rd(A_RUN, d);  chk("R8 stale kept", d, 32'h80);
    reg_wr(A_DONE, 5);
    reg_rd(A_RUN, d);  chk("R8 back to idle", d, 32'hFF);

    // R10 stack full
    for (int n = 0; n < DEPTH; n++) begin
      set_cand(1, 50 + n, 8'hC0 >> n, 1);
      reg_rd(A_ACK, d); chk("R10 fill ack", d, 32'(50 + n));
    end
    set_cand(1, 60, 0, 1);
    chk("R10 full irq", 32'(irq), 0);
    reg_rd(A_ACK, d); chk("R10 full spurious", d, SPUR);
    reg_rd(A_RUN, d); chk("R10 running kept", d, 32'(8'hC0 >> (DEPTH - 1)));
    set_cand(0, 0, 0, 1);
    for (int n = DEPTH - 1; n >= 0; n--) reg_wr(A_DONE, 32'(50 + n));
    reg_rd(A_RUN, d); chk("R10 drained", d, 32'hFF);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule